// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the byte-level ROM command handler inside a 1-Wire slave. It holds a fixed 64-bit identity built at elaboration from a family code and a serial number. The top byte of that identity is a CRC8 computed over the lower 56 bits. After every bus reset the block collects one command byte from the link layer and runs the matching ROM routine: it sends the identity, compares it, takes part in a bitwise search, or selects the device at once. When a routine completes, the single flag `rom_selected_o` opens the way to the memory command layer.

The link layer handles all analog slot timing. For each slot it gives the block one single-cycle event:
- a received write bit, on `wr_valid_i` with `wr_bit_i`;
- a read slot request, on `rd_req_i`. The block presents the bit to send on `rd_bit_o` before the event, and the event consumes that bit;
- a bus reset, on `bus_reset_i`.

A read slot answered with 1 leaves the wired-AND bus released. This lets the device drop out of a search or sit idle without disturbing other devices.

Top module: `onewire_rom_layer`

## Requirements
- R1: After `rst_n` is released, `rom_selected_o` is 0, the block waits for a command byte, and every read slot returns 1.
- R2: Identity bit positions: bits [7:0] hold the family code and bits [55:8] the serial number. Bits [63:56] hold the CRC8 of bits [55:0], using polynomial x^8+x^5+x^4+1 with a zero start value and bit 0 shifted in first. Running all 64 identity bits through that CRC leaves zero.
- R3: The command byte is received bit 0 first. The codes are: 33h send identity, 55h compare identity, F0h search, CCh skip.
- R4: After 33h, 64 read slots return the identity bit 0 first. The device is selected once the 64th slot has been taken.
- R5: After 55h, 64 write bits are compared with the identity bit 0 first. The device is selected once the 64th bit has been received, provided every bit matched.
- R6: A compare mismatch makes the device idle until the next bus reset. While idle it is never selected, every read slot returns 1, and further write bits have no effect.
- R7: After F0h, each of the 64 bits takes three slots in order: a read slot returning the identity bit, a read slot returning its complement, and a write slot carrying the master's direction. If all 64 directions match, the device is selected.
- R8: A search direction bit that differs from the identity bit makes the device idle until the next bus reset, with the behaviour of R6.
- R9: After CCh the device is selected in the cycle after the eighth command bit, without any identity exchange.
- R10: Any other command byte makes the device idle until the next bus reset. It is not selected, and its read slots return 1.
- R11: A bus reset at any point clears `rom_selected_o` in the next cycle and restarts command reception. A write bit arriving in the same cycle as a bus reset is discarded.
- R12: Read slots during command reception return 1 and do not disturb the command byte being assembled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: a bus reset was seen |
| wr_valid_i | input | 1 | One-cycle pulse: a write slot delivered `wr_bit_i` |
| wr_bit_i | input | 1 | Received bit value |
| rd_req_i | input | 1 | One-cycle pulse: a read slot consumes `rd_bit_o` |
| rd_bit_o | output | 1 | Bit to send in the next read slot (1 = release) |
| rom_selected_o | output | 1 | Device selected; memory commands may follow |

## Verification
A bus reset and a received write bit can arrive in the same cycle. The reset must win, and the bit must not enter the new command byte. The bench provokes this by pulsing the reset together with a 1 bit and then sending a full skip command. If the stray bit had been kept, the assembled byte would be 99h and the device would stay unselected; it must instead be selected. A second case resets in the middle of an identity readout and checks that selection is cleared and that a fresh command is decoded from its first bit.

// File: rtl/onewire_rom_pkg.sv
package onewire_rom_pkg;

  localparam int unsigned FAM_W    = 8;
  localparam int unsigned SER_W    = 48;
  localparam int unsigned CRC_W    = 8;
  localparam int unsigned ID_W     = FAM_W + SER_W + CRC_W;
  localparam int unsigned BODY_W   = FAM_W + SER_W;
  localparam int unsigned IDX_W    = $clog2(ID_W);
  localparam int unsigned CMD_W    = 8;

  localparam logic [CMD_W-1:0] CMD_SEND_ID  = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH_ID = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_SKIP     = 8'hCC;

  // reflected form of x^8+x^5+x^4+1
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  typedef enum logic [2:0] {
    ST_WAIT_CMD = 3'd0,
    ST_SEND_ID  = 3'd1,
    ST_MATCH    = 3'd2,
    ST_SRCH_TRU = 3'd3,
    ST_SRCH_CMP = 3'd4,
    ST_SRCH_DIR = 3'd5,
    ST_SELECTED = 3'd6,
    ST_IDLE     = 3'd7
  } rom_state_e;

  function automatic logic [CRC_W-1:0] id_crc8(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = 0; i < int'(BODY_W); i++) begin
      fb  = acc[0] ^ body[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ CRC_POLY_REFL;
    end
    return acc;
  endfunction

endpackage

// File: rtl/onewire_rom_id_store.sv
module onewire_rom_id_store
  import onewire_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2B,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_0000_0001
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             id_bit_o
);

  localparam logic [BODY_W-1:0] BODY   = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [CRC_W-1:0]  ID_CRC = id_crc8(BODY);
  localparam logic [ID_W-1:0]   ID     = {ID_CRC, BODY};

  logic [ID_W-1:0] id_vec;

  // lay the identity out byte by byte so each field is visible
  for (genvar b = 0; b < int'(ID_W / 8); b++) begin : g_byte
    assign id_vec[b*8 +: 8] = ID[b*8 +: 8];
  end

  always_comb begin
    id_bit_o = id_vec[idx_i];
  end

endmodule

// File: rtl/onewire_rom_cmd_shift.sv
module onewire_rom_cmd_shift
  import onewire_rom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [CMD_W-1:0] byte_o
);

  localparam int unsigned CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    byte_o = {bit_i, sh_q[CMD_W-1:1]};
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      sh_d = {bit_i, sh_q[CMD_W-1:1]};
      if (cnt_q == CNT_W'(CMD_W - 1)) begin
        done_o = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  cmd_cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cnt_q == '0));

endmodule

// File: rtl/onewire_rom_idx_ctr.sv
module onewire_rom_idx_ctr
  import onewire_rom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (inc_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(ID_W - 1));

  // R4
  idx_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !last_o);

endmodule

// File: rtl/onewire_rom_layer.sv
module onewire_rom_layer
  import onewire_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2B,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_0000_0001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset_i,
  input  logic wr_valid_i,
  input  logic wr_bit_i,
  input  logic rd_req_i,
  output logic rd_bit_o,
  output logic rom_selected_o
);

  rom_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx;
  logic             idx_last, idx_clr, idx_inc;
  logic             id_bit;
  logic             cmd_en, cmd_done;
  logic [CMD_W-1:0] cmd_byte;

  onewire_rom_id_store #(
    .FAMILY_CODE (FAMILY_CODE),
    .SERIAL_NUM  (SERIAL_NUM)
  ) u_id (
    .idx_i    (idx),
    .id_bit_o (id_bit)
  );

  assign cmd_en = wr_valid_i && (st_q == ST_WAIT_CMD) && !bus_reset_i;

  onewire_rom_cmd_shift u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (bus_reset_i),
    .en_i   (cmd_en),
    .bit_i  (wr_bit_i),
    .done_o (cmd_done),
    .byte_o (cmd_byte)
  );

  onewire_rom_idx_ctr u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (idx_clr),
    .inc_i  (idx_inc),
    .idx_o  (idx),
    .last_o (idx_last)
  );

  // next state
  always_comb begin
    st_d    = st_q;
    idx_inc = 1'b0;
    idx_clr = bus_reset_i || (st_q == ST_WAIT_CMD);
    if (bus_reset_i) begin
      st_d = ST_WAIT_CMD;
    end else begin
      unique case (st_q)
        ST_WAIT_CMD: begin
          if (cmd_done) begin
            unique case (cmd_byte)
              CMD_SEND_ID:  st_d = ST_SEND_ID;
              CMD_MATCH_ID: st_d = ST_MATCH;
              CMD_SEARCH:   st_d = ST_SRCH_TRU;
              CMD_SKIP:     st_d = ST_SELECTED;
              default:      st_d = ST_IDLE;
            endcase
          end
        end
        ST_SEND_ID: begin
          if (rd_req_i) begin
            if (idx_last) st_d = ST_SELECTED;
            else          idx_inc = 1'b1;
          end
        end
        ST_MATCH: begin
          if (wr_valid_i) begin
            if (wr_bit_i != id_bit) st_d = ST_IDLE;
            else if (idx_last)      st_d = ST_SELECTED;
            else                    idx_inc = 1'b1;
          end
        end
        ST_SRCH_TRU: begin
          if (rd_req_i) st_d = ST_SRCH_CMP;
        end
        ST_SRCH_CMP: begin
          if (rd_req_i) st_d = ST_SRCH_DIR;
        end
        ST_SRCH_DIR: begin
          if (wr_valid_i) begin
            if (wr_bit_i != id_bit) begin
              st_d = ST_IDLE;
            end else if (idx_last) begin
              st_d = ST_SELECTED;
            end else begin
              st_d    = ST_SRCH_TRU;
              idx_inc = 1'b1;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT_CMD;
    else        st_q <= st_d;
  end

  // bit presented for the next read slot; 1 releases the bus
  always_comb begin
    unique case (st_q)
      ST_SEND_ID,
      ST_SRCH_TRU: rd_bit_o = id_bit;
      ST_SRCH_CMP: rd_bit_o = ~id_bit;
      default:     rd_bit_o = 1'b1;
    endcase
  end

  assign rom_selected_o = (st_q == ST_SELECTED);

  // R7
  srch_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRCH_CMP && $past(st_q) == ST_SRCH_TRU) |-> (rd_bit_o != $past(rd_bit_o)));

  // R6
  idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !bus_reset_i) |=> (st_q == ST_IDLE));

  // R11
  bus_reset_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> !rom_selected_o);

  // R5
  select_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_selected_o) |-> ($past(idx_last) || $past(st_q) == ST_WAIT_CMD));

endmodule

// File: tb/onewire_rom_layer_tb.sv
module onewire_rom_layer_tb;

  localparam logic [7:0]  TB_FAM = 8'h1D;
  localparam logic [47:0] TB_SER = 48'hA35C_0F91_7E24;

  logic clk, rst_n, bus_reset_i, wr_valid_i, wr_bit_i, rd_req_i;
  logic rd_bit_o, rom_selected_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [63:0] exp_id;

  onewire_rom_layer #(.FAMILY_CODE(TB_FAM), .SERIAL_NUM(TB_SER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
    .wr_valid_i(wr_valid_i), .wr_bit_i(wr_bit_i), .rd_req_i(rd_req_i),
    .rd_bit_o(rd_bit_o), .rom_selected_o(rom_selected_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // taps at bits 7,3,2 of the reflected register
  function automatic logic [7:0] tb_crc(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    logic f;
    for (int i = 0; i < n; i++) begin
      f = c[0] ^ v[i];
      c = {f, c[7:1]};
      c[3] = c[3] ^ f;
      c[2] = c[2] ^ f;
    end
    return c;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); wr_valid_i = 1'b1; wr_bit_i = b;
    @(negedge clk); wr_valid_i = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); b = rd_bit_o; rd_req_i = 1'b1;
    @(negedge clk); rd_req_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic bus_reset();
    @(negedge clk); bus_reset_i = 1'b1;
    @(negedge clk); bus_reset_i = 1'b0;
  endtask

  // {command, expected selection after the command path}
  localparam logic [8:0] VEC [0:6] = '{
    {8'h33, 1'b1}, {8'h55, 1'b1}, {8'hF0, 1'b1}, {8'hCC, 1'b1},
    {8'hA5, 1'b0}, {8'h00, 1'b0}, {8'h3C, 1'b0}
  };

  initial begin
    logic [63:0] got;
    logic        b, t, c;
    rst_n = 1'b0; bus_reset_i = 1'b0; wr_valid_i = 1'b0; wr_bit_i = 1'b0; rd_req_i = 1'b0;
    exp_id = {tb_crc({8'h00, TB_SER, TB_FAM}, 56), TB_SER, TB_FAM};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rom_selected_o == 1'b0, "R1 selected after reset", 64'(rom_selected_o), 64'd0);
    chk(rd_bit_o == 1'b1, "R1 read slot after reset", 64'(rd_bit_o), 64'd1);

    for (int v = 0; v < 7; v++) begin
      logic [7:0] cmd;
      cmd = VEC[v][8:1];
      bus_reset();
      send_byte(cmd);
      case (cmd)
        8'h33: begin
          for (int i = 0; i < 64; i++) begin read_bit(b); got[i] = b; end
          chk(got == exp_id, "R4 identity readout", got, exp_id);
          chk(got[63:56] == tb_crc(got, 56), "R2 stored crc", 64'(got[63:56]), 64'(tb_crc(got, 56)));
          chk(tb_crc(got, 64) == 8'h00, "R2 crc residue", 64'(tb_crc(got, 64)), 64'd0);
          chk(got[7:0] == TB_FAM, "R2 family field", 64'(got[7:0]), 64'(TB_FAM));
        end
        8'h55: for (int i = 0; i < 64; i++) send_bit(exp_id[i]);
        8'hF0: begin
          for (int i = 0; i < 64; i++) begin
            read_bit(t); read_bit(c);
            if (t !== exp_id[i] || c !== ~exp_id[i])
              chk(1'b0, "R7 search bit pair", {62'd0, t, c}, {62'd0, exp_id[i], ~exp_id[i]});
            send_bit(t);
          end
          checks = checks + 1;
        end
        8'hCC: ;
        default: begin
          read_bit(b);
          chk(b == 1'b1, "R10 idle read slot", 64'(b), 64'd1);
        end
      endcase
      @(negedge clk);
      chk(rom_selected_o == VEC[v][0], $sformatf("R3 R9 command %h selection", cmd),
          64'(rom_selected_o), 64'(VEC[v][0]));
    end

    // R9 skip selects in cycle after 8th bit
    bus_reset();
    for (int i = 0; i < 7; i++) send_bit(8'hCC >> i);
    chk(rom_selected_o == 1'b0, "R9 not before 8th bit", 64'(rom_selected_o), 64'd0);
    @(negedge clk); wr_valid_i = 1'b1; wr_bit_i = 1'b1;
    @(negedge clk); wr_valid_i = 1'b0;
    chk(rom_selected_o == 1'b1, "R9 selected after 8th bit", 64'(rom_selected_o), 64'd1);

    // R11 reset clears selection
    bus_reset();
    chk(rom_selected_o == 1'b0, "R11 reset clears selection", 64'(rom_selected_o), 64'd0);

    // R6 match mismatch at bit 17
    bus_reset();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(i == 17 ? ~exp_id[i] : exp_id[i]);
    read_bit(b);
    chk(rom_selected_o == 1'b0 && b == 1'b1, "R6 match mismatch idle", {62'd0, rom_selected_o, b}, 64'd1);

    // R8 search diverges at bit 40
    bus_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 41; i++) begin
      read_bit(t); read_bit(c);
      send_bit(i == 40 ? ~t : t);
    end
    read_bit(t); read_bit(c);
    chk(t == 1'b1 && c == 1'b1, "R8 search dropout releases bus", {62'd0, t, c}, 64'd3);
    for (int i = 41; i < 64; i++) send_bit(exp_id[i]);
    chk(rom_selected_o == 1'b0, "R8 no select after dropout", 64'(rom_selected_o), 64'd0);

    // R12 read slots during command reception
    bus_reset();
    send_bit(1'b1); send_bit(1'b1);
    read_bit(b);
    chk(b == 1'b1, "R12 read during command", 64'(b), 64'd1);
    for (int i = 2; i < 8; i++) send_bit(8'h33 >> i);
    read_bit(b);
    chk(b == exp_id[0], "R12 command intact after read", 64'(b), 64'(exp_id[0]));

    // R11 reset mid readout, then fresh command
    bus_reset();
    send_byte(8'h33);
    for (int i = 0; i < 20; i++) read_bit(b);
    bus_reset();
    send_byte(8'hCC);
    @(negedge clk);
    chk(rom_selected_o == 1'b1, "R11 restart after mid reset", 64'(rom_selected_o), 64'd1);

    // R11 write bit coincident with bus reset is discarded
    @(negedge clk); bus_reset_i = 1'b1; wr_valid_i = 1'b1; wr_bit_i = 1'b1;
    @(negedge clk); bus_reset_i = 1'b0; wr_valid_i = 1'b0;
    send_byte(8'hCC);
    @(negedge clk);
    chk(rom_selected_o == 1'b1, "R11 coincident bit discarded", 64'(rom_selected_o), 64'd1);

    // R1 hard reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rom_selected_o == 1'b0, "R1 hard reset clears", 64'(rom_selected_o), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule